// File: doc/BRIEF.md
# Watchdog countdown timer with keyed restart

This block is a watchdog for a processor subsystem. Software sets a reload value and turns the timer on through a control register. It then has to write a fixed key to the restart register regularly. If it fails to, the live counter runs down to zero and the block raises a reset request for one clock. Some other block acts on that request. The counter can also be read back as a status word.

The countdown advances on one of two tick sources. One is every bus clock. The other is a slow tick of about 1 MHz, made by a prescaler with a parameter-set divide ratio. A control bit picks between them. Software can also ask for a reset at once by writing a 32-bit key to a separate register, but only while the reset-mode field selects SoC mode.

An external input, driven while the memory controller is itself being reset, vetoes the expiry reset. When this input is high at expiry, no request is raised, counting stops and the control register is cleared to zero.

Top module: `wdog_ctl`

## Requirements
- R1: After reset, the counter (offset 0x00) and the reload value (offset 0x04) read 0x014FB180, and the control register (offset 0x0C) reads 0x00000010.
- R2: A write to control stores the data with bits 11:8 forced to zero. Every other bit, including the tick select bit 4, reads back as written.
- R3: A write to the restart register (offset 0x08) whose low 16 bits are 0x4755 loads the counter from the reload value on the next clock, whatever the upper 16 bits are. Any other value leaves the counter unchanged.
- R4: While the timer runs and control bit 4 is 0, the counter drops by one on every clock.
- R5: While the timer runs and control bit 4 is 1, the counter drops by one every PRESC_DIV clocks.
- R6: In the cycle after the counter reaches zero while running, rst_req is high for exactly one clock. The counter then stays at zero and does not run again until a restart or a new enable.
- R7: If mem_rst_hold is high when the counter expires, rst_req stays low and the control register reads zero afterwards.
- R8: Writing control with bit 0 set while bit 0 is clear loads the counter from the reload value and starts it. Clearing bit 0 freezes the counter. A control write that leaves bit 0 set does not reload the counter.
- R9: Writing exactly 0xAEEDF123 to offset 0x24 raises rst_req for one clock, starting the cycle after the write, only when control bits 6:5 are 0. Any other value, or any other mode, raises nothing.
- R10: Reads of the restart register or of an unmapped offset return zero. Writes to the counter offset are ignored.
- R11: While the timer is stopped, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| mem_rst_hold | input | 1 | High while the memory controller is in reset; vetoes expiry resets |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The properties assume that mem_rst_hold and every bus input are synchronous to clk. They also assume that a single access occupies a cycle, so a restart, a control write and a software-reset write never fall in the same cycle. The veto property further assumes that no software-reset key lands in the cycle of a vetoed expiry. The bench changes every input at the falling edge and spaces each access by at least one idle cycle. It turns the veto input on and off only while the timer is stopped or well before expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 32;

  // byte offsets of the mapped registers
  localparam int OFS_COUNT  = 'h00;
  localparam int OFS_RELOAD = 'h04;
  localparam int OFS_KICK   = 'h08;
  localparam int OFS_CTRL   = 'h0C;
  localparam int OFS_SWRST  = 'h24;

  localparam logic [15:0]      KICK_KEY  = 16'h4755;
  localparam logic [REG_W-1:0] SWRST_KEY = 32'hAEEDF123;
  localparam logic [REG_W-1:0] CNT_INIT  = 32'h014FB180;
  localparam logic [REG_W-1:0] CTRL_INIT = 32'h00000010;

  localparam int CB_EN   = 0;
  localparam int CB_SLOW = 4;
  localparam int CB_MODE = 5;  // two-bit field at 6:5

  // control writes lose bits 11:8
  function automatic logic [REG_W-1:0] ctrl_clean(input logic [REG_W-1:0] d);
    return d & ~(REG_W'(32'h0000_0F00));
  endfunction

  function automatic logic kick_ok(input logic [REG_W-1:0] d);
    return d[15:0] == KICK_KEY;
  endfunction

  function automatic logic swrst_ok(input logic [REG_W-1:0] d, input logic [1:0] mode);
    return (d == SWRST_KEY) && (mode == 2'd0);
  endfunction

  function automatic logic [REG_W-1:0] count_step(input logic [REG_W-1:0] c);
    return c - REG_W'(1);
  endfunction
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int DIV = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end
      assign tick_o = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [REG_W-1:0] count_i,
  input  logic             veto_clr_i,
  output logic [REG_W-1:0] reload_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic             restart_o,
  output logic             en_rise_o,
  output logic             en_fall_o,
  output logic             sw_hit_o
);
  logic             wr, rd;
  logic             hit_reload, hit_kick, hit_ctrl, hit_swrst;
  logic [REG_W-1:0] reload_q, ctrl_q;

  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;

  assign hit_reload = wr && (bus_addr == AW'(OFS_RELOAD));
  assign hit_kick   = wr && (bus_addr == AW'(OFS_KICK));
  assign hit_ctrl   = wr && (bus_addr == AW'(OFS_CTRL));
  assign hit_swrst  = wr && (bus_addr == AW'(OFS_SWRST));

  assign restart_o = hit_kick && kick_ok(bus_wdata);
  assign en_rise_o = hit_ctrl && bus_wdata[CB_EN] && !ctrl_q[CB_EN];
  assign en_fall_o = hit_ctrl && !bus_wdata[CB_EN] && ctrl_q[CB_EN];
  assign sw_hit_o  = hit_swrst && swrst_ok(bus_wdata, ctrl_q[CB_MODE+1:CB_MODE]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= CNT_INIT;
      ctrl_q   <= CTRL_INIT;
    end else begin
      if (hit_reload) reload_q <= bus_wdata;
      // a bus write in the same cycle overrides the veto clear
      if (hit_ctrl)        ctrl_q <= ctrl_clean(bus_wdata);
      else if (veto_clr_i) ctrl_q <= '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        AW'(OFS_COUNT):  bus_rdata = count_i;
        AW'(OFS_RELOAD): bus_rdata = reload_q;
        AW'(OFS_CTRL):   bus_rdata = ctrl_q;
        default:         bus_rdata = '0;
      endcase
    end
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             en_rise_i,
  input  logic             en_fall_i,
  input  logic             enabled_i,
  input  logic [REG_W-1:0] reload_i,
  input  logic             veto_i,
  input  logic             sw_hit_i,
  output logic [REG_W-1:0] count_o,
  output logic             armed_o,
  output logic             expire_o,
  output logic             veto_clr_o,
  output logic             rst_req_o
);
  logic [REG_W-1:0] count_q;
  logic             armed_q, req_q;

  assign expire_o   = armed_q && (count_q == '0);
  assign veto_clr_o = expire_o && veto_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= CNT_INIT;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= (expire_o && !veto_i) || sw_hit_i;

      if (restart_i || en_rise_i)
        count_q <= reload_i;
      else if (armed_q && tick_i && (count_q != '0))
        count_q <= count_step(count_q);

      if (en_fall_i)      armed_q <= 1'b0;
      else if (en_rise_i) armed_q <= 1'b1;
      else if (restart_i) armed_q <= enabled_i;
      else if (expire_o)  armed_q <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign armed_o   = armed_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PRESC_DIV = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          mem_rst_hold,
  output logic          rst_req
);
  logic             slow_tick, tick;
  logic             restart_evt, en_rise, en_fall, sw_hit;
  logic             expire_evt, veto_clr, armed;
  logic [REG_W-1:0] count_q, reload_q, ctrl_q;

  wdog_tick #(.DIV(PRESC_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (slow_tick)
  );

  assign tick = ctrl_q[CB_SLOW] ? slow_tick : 1'b1;

  wdog_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .count_i    (count_q),
    .veto_clr_i (veto_clr),
    .reload_o   (reload_q),
    .ctrl_o     (ctrl_q),
    .restart_o  (restart_evt),
    .en_rise_o  (en_rise),
    .en_fall_o  (en_fall),
    .sw_hit_o   (sw_hit)
  );

  wdog_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .restart_i  (restart_evt),
    .en_rise_i  (en_rise),
    .en_fall_i  (en_fall),
    .enabled_i  (ctrl_q[CB_EN]),
    .reload_i   (reload_q),
    .veto_i     (mem_rst_hold),
    .sw_hit_i   (sw_hit),
    .count_o    (count_q),
    .armed_o    (armed),
    .expire_o   (expire_evt),
    .veto_clr_o (veto_clr),
    .rst_req_o  (rst_req)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_hold,
  input logic        rst_req,
  input logic        tick,
  input logic        restart_evt,
  input logic        en_rise,
  input logic        sw_hit,
  input logic        expire_evt,
  input logic        armed,
  input logic [31:0] count_q,
  input logic [31:0] reload_q,
  input logic [31:0] ctrl_q
);
  p_ctrl_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[11:8] == 4'h0);

  p_restart_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (count_q == $past(reload_q)));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && count_q != 32'd0 && !restart_evt && !en_rise)
      |=> (count_q == $past(count_q) - 32'd1));

  p_expire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !mem_hold) |=> rst_req);

  p_expire_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !restart_evt && !en_rise) |=> !armed);

  p_veto_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && mem_hold && !sw_hit) |=> !rst_req);

  p_enable_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (armed && count_q == $past(reload_q)));

  p_sw_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit |=> rst_req);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !restart_evt && !en_rise) |=> $stable(count_q));
endmodule

bind wdog_ctl wdog_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_hold    (mem_rst_hold),
  .rst_req     (rst_req),
  .tick        (tick),
  .restart_evt (restart_evt),
  .en_rise     (en_rise),
  .sw_hit      (sw_hit),
  .expire_evt  (expire_evt),
  .armed       (armed),
  .count_q     (count_q),
  .reload_q    (reload_q),
  .ctrl_q      (ctrl_q)
);

// File: tb/tb_wdog_ctl.sv
module tb_wdog_ctl;
  localparam int AW  = 8;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          mem_rst_hold = 1'b0;
  logic          rst_req;

  int tests = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_ctl #(.AW(AW), .PRESC_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_rst_hold(mem_rst_hold), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_n && rst_req) pulses++;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  // {write, addr, data, expected, requirement}
  localparam int NV = 17;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,        32'h014FB180, 4'd1},  // R1 counter
    {1'b0, 8'h04, 32'h0,        32'h014FB180, 4'd1},  // R1 reload
    {1'b0, 8'h0C, 32'h0,        32'h00000010, 4'd1},  // R1 control
    {1'b0, 8'h08, 32'h0,        32'h0,        4'd10}, // R10 restart reads zero
    {1'b0, 8'h40, 32'h0,        32'h0,        4'd10}, // R10 unmapped
    {1'b1, 8'h04, 32'h00000123, 32'h0,        4'd3},
    {1'b0, 8'h04, 32'h0,        32'h00000123, 4'd3},
    {1'b1, 8'h08, 32'h12340000, 32'h0,        4'd3},  // R3 wrong key
    {1'b0, 8'h00, 32'h0,        32'h014FB180, 4'd3},
    {1'b1, 8'h08, 32'hABCD4755, 32'h0,        4'd3},  // R3 key in low half
    {1'b0, 8'h00, 32'h0,        32'h00000123, 4'd3},
    {1'b1, 8'h00, 32'h00005555, 32'h0,        4'd10}, // R10 status write
    {1'b0, 8'h00, 32'h0,        32'h00000123, 4'd10},
    {1'b1, 8'h0C, 32'h0000FF40, 32'h0,        4'd2},
    {1'b0, 8'h0C, 32'h0,        32'h0000F040, 4'd2},  // R2 bits 11:8 cleared
    {1'b1, 8'h0C, 32'h00000000, 32'h0,        4'd2},
    {1'b0, 8'h0C, 32'h0,        32'h00000000, 4'd2}   // R2 bit 4 writable
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, v2;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:68], VEC[i][67:36]);
      else begin
        rd(VEC[i][75:68], v);
        check(v, VEC[i][35:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
      end
    end

    // R11: stopped counter holds
    repeat (10) @(negedge clk);
    rd(8'h00, v); check(v, 32'h123, "R11 hold while stopped");

    // R4 / R6 / R8: per-clock countdown from reload 3
    p0 = pulses;
    wr(8'h04, 32'd3);
    wr(8'h0C, 32'h1);
    rd(8'h00, v); check(v, 32'd3, "R8 enable loads reload");
    @(negedge clk); rd(8'h00, v); check(v, 32'd2, "R4 step");
    @(negedge clk); rd(8'h00, v); check(v, 32'd1, "R4 step");
    @(negedge clk); rd(8'h00, v); check(v, 32'd0, "R4 step to zero");
    check({31'd0, rst_req}, 32'd0, "R6 no request at zero");
    @(negedge clk); check({31'd0, rst_req}, 32'd1, "R6 request after zero");
    @(negedge clk); check({31'd0, rst_req}, 32'd0, "R6 single cycle");
    repeat (5) @(negedge clk);
    rd(8'h00, v); check(v, 32'd0, "R6 stopped at zero");
    check(pulses - p0, 1, "R6 one pulse");

    // R3 restart re-arms, R8 disable freezes
    p0 = pulses;
    wr(8'h08, 32'h00004755);
    wr(8'h0C, 32'h0);
    rd(8'h00, v); check(v, 32'd1, "R8 disable freezes");
    repeat (6) @(negedge clk);
    rd(8'h00, v); check(v, 32'd1, "R8 frozen");
    check(pulses - p0, 0, "R8 no pulse when frozen");

    // R7: veto on expiry
    mem_rst_hold = 1'b1;
    p0 = pulses;
    wr(8'h0C, 32'h1);
    rd(8'h00, v); check(v, 32'd3, "R8 re-enable reloads");
    repeat (8) @(negedge clk);
    check(pulses - p0, 0, "R7 no request under veto");
    rd(8'h0C, v); check(v, 32'd0, "R7 control cleared");
    rd(8'h00, v); check(v, 32'd0, "R7 counter stopped");
    mem_rst_hold = 1'b0;

    // R5: slow tick
    wr(8'h04, 32'd100);
    wr(8'h0C, 32'h11);
    rd(8'h00, v);
    repeat (8) @(negedge clk);
    rd(8'h00, v2); check(v - v2, 32'd2, "R5 two ticks per 8 clocks");
    repeat (16) @(negedge clk);
    rd(8'h00, v); check(v2 - v, 32'd4, "R5 four ticks per 16 clocks");
    wr(8'h0C, 32'h11);
    rd(8'h00, v2);
    check({31'd0, (v2 < 32'd100)}, 32'd1, "R8 enabled rewrite no reload");
    wr(8'h0C, 32'h10);

    // R9: software reset key
    p0 = pulses;
    wr(8'h24, 32'hAEEDF124);
    @(negedge clk);
    check(pulses - p0, 0, "R9 wrong key");
    wr(8'h24, 32'hAEEDF123);
    check({31'd0, rst_req}, 32'd1, "R9 key raises request");
    @(negedge clk);
    check({31'd0, rst_req}, 32'd0, "R9 single cycle");
    check(pulses - p0, 1, "R9 one pulse");
    p0 = pulses;
    wr(8'h0C, 32'h30);
    wr(8'h24, 32'hAEEDF123);
    @(negedge clk);
    wr(8'h0C, 32'h50);
    wr(8'h24, 32'hAEEDF123);
    @(negedge clk);
    check(pulses - p0, 0, "R9 non-SoC modes ignore key");

    // R1: reset while running
    wr(8'h04, 32'd50);
    wr(8'h0C, 32'h1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, v); check(v, 32'h014FB180, "R1 counter after reset");
    rd(8'h04, v); check(v, 32'h014FB180, "R1 reload after reset");
    rd(8'h0C, v); check(v, 32'h00000010, "R1 control after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule